// File: doc/BRIEF.md
# Gated Down-Counter Timer Core

This block is the counting heart of a general-purpose timer. It holds a down-counter, by default 16 bits wide, which steps down by one on each count strobe while the timer is allowed to run. The timer runs only when software has set its run bit and its clock-enable bit. When gate control is switched on, an active-low gate input must also be held low. A compare value marks a point in the count sequence. Three sticky event flags record a counter timeout, a match with the compare value, and edges on the gate input.

Software reads a seven-bit status word and clears flags by writing ones into it. Each flag can separately be routed to a registered interrupt request line. A simple output level toggles on every timeout. The count value is also brought out so the counter can be watched directly.

Top module: `gdt_timer_core`

## Requirements
- R1: After a synchronous active-low reset the count is all ones, and the three flags, `irq` and `tout` are all zero.
- R2: Status bit 4 (running) is 1 exactly when `run_en` and `clk_en` are both 1 and either `gate_en` is 0 or `gate_n` is 0. While running, each clock with `count_stb` high lowers the count by one. Otherwise the count holds.
- R3: In the clock where `run_en` rises from 0 to 1, the count is loaded with all ones and any strobe in that clock is ignored.
- R4: A strobe that takes the count from 1 to 0 sets the timeout flag (status bit 0). A strobe at count 0 wraps the count to all ones.
- R5: A strobe that brings the count to a value equal to `cmp_val` sets the compare flag (status bit 2).
- R6: While `gate_en` is 1, any change of `gate_n` sets the gate flag (status bit 1). While `gate_en` is 0, changes of `gate_n` leave the flag untouched.
- R7: A clock with `st_wr` high clears each flag whose bit in `st_wdata` is 1. Flag bits written as 0 keep their value. Bits 3 to 6 of `st_wdata` have no effect.
- R8: Clearing `run_en` leaves all three flags unchanged.
- R9: When a flag's set event and a write that clears it fall in the same clock, the flag ends up set.
- R10: Status bit 3 equals the level of `gate_n` (1 when negated, 0 when asserted).
- R11: Status bit 6 is 1 exactly when the count is less than or equal to `cmp_val`.
- R12: `irq` is the OR of the flags whose `irq_en` bit is set, registered one clock after the flags. `irq_en` bit 0 covers timeout, bit 1 covers gate and bit 2 covers compare. A flag still sets while its enable is 0.
- R13: `tout`, also shown as status bit 5, inverts on every timeout event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Software run bit |
| clk_en | input | 1 | Count clock enable bit |
| gate_en | input | 1 | Enables gate control of counting and the gate flag |
| gate_n | input | 1 | Gate input, active low |
| count_stb | input | 1 | One count event per clock it is high |
| cmp_val | input | CNT_W | Compare value |
| irq_en | input | 3 | Per-flag interrupt enables (timeout, gate, compare) |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 7 | Status write data, ones clear flags in bits 0 to 2 |
| status | output | 7 | Flags, gate level, running, output level, compare window |
| count | output | CNT_W | Current counter value |
| tout | output | 1 | Output level, toggles on timeout |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with `CNT_W` set to 4, which gives a count range of only sixteen values. With that width, a full run from reload down to timeout and on through the wrap takes just a few dozen clocks. Two consecutive timeouts, and so both directions of the output toggle, fit easily in the run. Compare hits, window edges, gate edges and clear-versus-set collisions are all placed at known counts in that short range.

// File: rtl/gdt_pkg.sv
// Package gdt_pkg
// Shared status bit positions and flag indices for the gated down-counter
// timer. Assumes the three sticky flags occupy status bits 0..2 in the same
// order as the interrupt enables, so one index serves both.
package gdt_pkg;
    localparam int ST_W     = 7;
    localparam int NFLAG    = 3;
    localparam int ST_TMO   = 0;
    localparam int ST_GATE  = 1;
    localparam int ST_CMP   = 2;
    localparam int ST_GLVL  = 3;
    localparam int ST_RUN   = 4;
    localparam int ST_OUT   = 5;
    localparam int ST_WIN   = 6;

    // Event pulses produced by the counter and gate logic for one clock.
    typedef struct packed {
        logic cmp;
        logic gate;
        logic tmo;
    } flag_ev_t;
endpackage

// File: rtl/gdt_count_unit.sv
// Module gdt_count_unit
// Down-counter with run qualification, reload on a run-bit rise, timeout and
// compare event detection, compare-window flag and a toggling output level.
// Assumes all inputs are synchronous to clk.
module gdt_count_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             clk_en,
    input  logic             gate_en,
    input  logic             gate_n,
    input  logic             count_stb,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_on,
    output logic             step,
    output logic             reload,
    output logic             tmo_ev,
    output logic             cmp_ev,
    output logic             cmp_win,
    output logic             tout
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};

    logic             run_q;
    logic [CNT_W-1:0] cnt_dec;

    // Remember the previous run bit to spot its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_en;
    end

    // Qualify counting and derive the per-clock events.
    always_comb begin
        reload  = run_en & ~run_q;
        cnt_on  = run_en & clk_en & (~gate_en | ~gate_n);
        step    = cnt_on & count_stb & ~reload;
        cnt_dec = cnt - CNT_ONE;
        tmo_ev  = step & (cnt == CNT_ONE);
        cmp_ev  = step & (cnt_dec == cmp_val);
        cmp_win = (cnt <= cmp_val);
    end

    // Counter register: reload wins over a step; a step at zero wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= CNT_FULL;
        else if (reload) cnt <= CNT_FULL;
        else if (step)   cnt <= cnt_dec;
    end

    // Output level flips once per timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)      tout <= 1'b0;
        else if (tmo_ev) tout <= ~tout;
    end
endmodule

// File: rtl/gdt_gate_watch.sv
// Module gdt_gate_watch
// Detects any edge on the active-low gate input while gate control is on.
// Assumes gate_n is already synchronous and idles negated (high) in reset.
module gdt_gate_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en,
    input  logic gate_n,
    output logic gate_ev
);
    logic gate_q;

    // Hold last gate level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= gate_n;
    end

    // An edge counts only when gate control is enabled.
    always_comb gate_ev = gate_en & (gate_n ^ gate_q);
endmodule

// File: rtl/gdt_flag_bank.sv
// Module gdt_flag_bank
// Sticky flags, set by event pulses and cleared by write-one strobes; a set
// in the same clock as a clear leaves the flag set.
module gdt_flag_bank #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_ev,
    input  logic          clr_wr,
    input  logic [NF-1:0] clr_mask,
    output logic [NF-1:0] flags
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        // One sticky bit: set dominates, write-one clears.
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= set_ev[i] | (flags[i] & ~(clr_wr & clr_mask[i]));
        end
    end
endmodule

// File: rtl/gdt_irq_out.sv
// Module gdt_irq_out
// Registered interrupt request: OR of flags masked by their enables.
module gdt_irq_out #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] flags,
    input  logic [NF-1:0] irq_en,
    output logic          irq
);
    // Sample the masked flags one clock after they change.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flags & irq_en);
    end
endmodule

// File: rtl/gdt_timer_core.sv
// Module gdt_timer_core
// Top of the gated down-counter timer: wires the counter, gate watcher,
// sticky flags and interrupt register, and assembles the status word.
// Assumes synchronous inputs and a synchronous active-low reset.
module gdt_timer_core
    import gdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             clk_en,
    input  logic             gate_en,
    input  logic             gate_n,
    input  logic             count_stb,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [2:0]       irq_en,
    input  logic             st_wr,
    input  logic [6:0]       st_wdata,
    output logic [6:0]       status,
    output logic [CNT_W-1:0] count,
    output logic             tout,
    output logic             irq
);
    logic             cnt_on_w, step_w, reload_w, tmo_ev_w, cmp_ev_w, cmp_win_w;
    logic             gate_ev_w;
    logic [NFLAG-1:0] flags_w;
    flag_ev_t         ev_w;

    gdt_count_unit #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .clk_en(clk_en),
        .gate_en(gate_en), .gate_n(gate_n), .count_stb(count_stb),
        .cmp_val(cmp_val), .cnt(count), .cnt_on(cnt_on_w), .step(step_w),
        .reload(reload_w), .tmo_ev(tmo_ev_w), .cmp_ev(cmp_ev_w),
        .cmp_win(cmp_win_w), .tout(tout)
    );

    gdt_gate_watch u_gate (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .gate_n(gate_n),
        .gate_ev(gate_ev_w)
    );

    // Gather event pulses in flag order.
    always_comb begin
        ev_w.tmo  = tmo_ev_w;
        ev_w.gate = gate_ev_w;
        ev_w.cmp  = cmp_ev_w;
    end

    gdt_flag_bank #(.NF(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_ev(ev_w), .clr_wr(st_wr),
        .clr_mask(st_wdata[NFLAG-1:0]), .flags(flags_w)
    );

    gdt_irq_out #(.NF(NFLAG)) u_irq (
        .clk(clk), .rst_n(rst_n), .flags(flags_w), .irq_en(irq_en), .irq(irq)
    );

    // Assemble the status word from flags and live conditions.
    always_comb begin
        status          = '0;
        status[ST_TMO]  = flags_w[ST_TMO];
        status[ST_GATE] = flags_w[ST_GATE];
        status[ST_CMP]  = flags_w[ST_CMP];
        status[ST_GLVL] = gate_n;
        status[ST_RUN]  = cnt_on_w;
        status[ST_OUT]  = tout;
        status[ST_WIN]  = cmp_win_w;
    end
endmodule

// File: rtl/gdt_timer_core_chk.sv
// Module gdt_timer_core_chk
// Property checker bound to gdt_timer_core; observes ports and internal
// event signals that separate submodules drive.
module gdt_timer_core_chk
    import gdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [6:0]       status,
    input logic [CNT_W-1:0] count,
    input logic [2:0]       irq_en,
    input logic             irq,
    input logic             st_wr,
    input logic [6:0]       st_wdata,
    input logic             step,
    input logic             reload,
    input logic             gate_ev
);
    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[ST_RUN] && !reload) |=> $stable(count));

    assert_reload_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count == {CNT_W{1'b1}}));

    assert_timeout_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count == CNT_W'(1)) |=> status[ST_TMO]);

    assert_wrap_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count == '0) |=> (count == {CNT_W{1'b1}}));

    assert_clear_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && st_wdata[ST_GATE] && !gate_ev) |=> !status[ST_GATE]);

    assert_sticky_tmo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_TMO] && !(st_wr && st_wdata[ST_TMO])) |=> status[ST_TMO]);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gate_ev |=> status[ST_GATE]);

    assert_window_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> status[ST_WIN]);

    assert_irq_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status[2:0] & irq_en)) |=> irq);

    assert_irq_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status[2:0] & irq_en)) |=> !irq);
endmodule

bind gdt_timer_core gdt_timer_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .status(status), .count(count),
    .irq_en(irq_en), .irq(irq), .st_wr(st_wr), .st_wdata(st_wdata),
    .step(step_w), .reload(reload_w), .gate_ev(gate_ev_w)
);

// File: tb/gdt_timer_core_test.sv
// Directed bench for gdt_timer_core with CNT_W = 4.
module gdt_timer_core_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n, run_en, clk_en, gate_en, gate_n, count_stb, st_wr;
    logic [W-1:0] cmp_val;
    logic [2:0]   irq_en;
    logic [6:0]   st_wdata, status;
    logic [W-1:0] count;
    logic         tout, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    gdt_timer_core #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .clk_en(clk_en),
        .gate_en(gate_en), .gate_n(gate_n), .count_stb(count_stb),
        .cmp_val(cmp_val), .irq_en(irq_en), .st_wr(st_wr), .st_wdata(st_wdata),
        .status(status), .count(count), .tout(tout), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input int n);
        count_stb = 1'b1;
        repeat (n) @(negedge clk);
        count_stb = 1'b0;
    endtask

    task automatic wr_status(input logic [6:0] d);
        st_wr = 1'b1; st_wdata = d;
        @(negedge clk);
        st_wr = 1'b0; st_wdata = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; run_en = 0; clk_en = 0; gate_en = 0; gate_n = 1;
        count_stb = 0; st_wr = 0; st_wdata = '0; cmp_val = '0; irq_en = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count", count, 15);
        check("R1 flags", status[2:0], 0);
        check("R1 irq", irq, 0);
        check("R1 tout", tout, 0);
    endtask

    task automatic t_count;
        run_en = 1; clk_en = 1;
        @(negedge clk);
        check("R2 running", status[4], 1);
        pulse(3);
        check("R2 count after 3", count, 12);
        clk_en = 0;
        pulse(2);
        check("R2 hold clk_en off", count, 12);
        check("R2 not running", status[4], 0);
        clk_en = 1;
    endtask

    task automatic t_reload;
        run_en = 0;
        @(negedge clk);
        run_en = 1; count_stb = 1;
        @(negedge clk);
        count_stb = 0;
        check("R3 reload", count, 15);
    endtask

    task automatic t_compare;
        cmp_val = 10;
        pulse(4);
        check("R11 window off at 11", status[6], 0);
        check("R5 no cmp yet", status[2], 0);
        pulse(1);
        check("R5 cmp flag", status[2], 1);
        check("R11 window on at 10", status[6], 1);
        check("R12 masked irq", irq, 0);
        irq_en = 3'b100;
        @(negedge clk);
        check("R12 irq enabled", irq, 1);
    endtask

    task automatic t_w1c;
        wr_status(7'b0000000);
        check("R7 zero keeps", status[2], 1);
        wr_status(7'b1111000);
        check("R7 upper bits ignored", status[2], 1);
        wr_status(7'b0000100);
        check("R7 one clears", status[2], 0);
        check("R12 irq latency", irq, 1);
        @(negedge clk);
        check("R12 irq drops", irq, 0);
        irq_en = 3'b000;
    endtask

    task automatic t_timeout;
        pulse(9);
        check("R4 count at 1", count, 1);
        check("R4 no timeout yet", status[0], 0);
        pulse(1);
        check("R4 timeout flag", status[0], 1);
        check("R13 tout high", tout, 1);
        check("R13 status out", status[5], 1);
        pulse(1);
        check("R4 wrap", count, 15);
    endtask

    task automatic t_keep;
        run_en = 0;
        @(negedge clk);
        check("R8 flag kept", status[0], 1);
        pulse(2);
        check("R2 hold run off", count, 15);
        run_en = 1;
        @(negedge clk);
    endtask

    task automatic t_tout2;
        pulse(15);
        check("R13 second toggle", tout, 0);
        check("R4 count zero", count, 0);
    endtask

    task automatic t_gate;
        wr_status(7'b0000111);
        check("R7 clear all", status[2:0], 0);
        gate_en = 1;
        @(negedge clk);
        check("R2 gate blocks", status[4], 0);
        check("R10 level negated", status[3], 1);
        pulse(2);
        check("R2 gate hold", count, 0);
        gate_n = 0;
        @(negedge clk);
        check("R6 gate flag", status[1], 1);
        check("R10 level asserted", status[3], 0);
        check("R2 gate open", status[4], 1);
        pulse(1);
        check("R2 gated count", count, 15);
        gate_n = 1; st_wr = 1; st_wdata = 7'b0000010;
        @(negedge clk);
        st_wr = 0; st_wdata = '0;
        check("R9 set wins", status[1], 1);
        wr_status(7'b0000010);
        check("R7 gate cleared", status[1], 0);
        gate_en = 0; gate_n = 0;
        @(negedge clk);
        check("R6 ignored when off", status[1], 0);
        check("R2 gate ignored", status[4], 1);
    endtask

    initial begin
        t_reset;
        t_count;
        t_reload;
        t_compare;
        t_w1c;
        t_timeout;
        t_keep;
        t_tout2;
        t_gate;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule